// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps a fast page mode DRAM refreshed and brings it out of power-up. After reset it waits a fixed settling pause. It then runs a burst of wake-up refresh cycles and only then declares the memory ready for normal access. From that point an interval timer adds one refresh obligation for each row slot of the refresh period. The default slot is 15.6 µs, which spreads 4096 rows over 64 ms.

Each refresh is a CAS-before-RAS cycle, so the memory's internal row counter picks the row and no address is needed. The scheduler asks the access controller for the bus. While the grant is held it drives the two strobes itself. If the controller keeps it waiting, for example behind long page bursts, obligations pile up in a saturating counter. Once the grant arrives they are run back to back.

Top module: `dram_ref_sched`

## Requirements
- R1: While reset is held and right after it, `ref_req`, `ref_drive`, `ready` and `pend_count` are 0, and both strobes are high.
- R2: `ref_req` stays low for the first INIT_CYCLES-1 clocks after reset is released. After clock INIT_CYCLES, `pend_count` equals WAKE_CYCLES (8) and `ref_req` is high.
- R3: `ready` rises at the clock on which the last of the WAKE_CYCLES wake-up refreshes completes. It is low before that and never falls again until reset.
- R4: Once `ready` is high, `pend_count` grows by one every INTERVAL_CYCLES clocks. The first increment comes INTERVAL_CYCLES clocks after `ready` rose.
- R5: `pend_count` saturates at PEND_MAX (8). Interval ticks that arrive while it is full are dropped.
- R6: `ref_req` is high exactly when `pend_count` is nonzero. A refresh cycle starts only while `ref_gnt` is high. Whenever `ref_drive` is low, both strobes are high.
- R7: In each refresh cycle, CAS falls while RAS is high and stays low for T_CSR clocks before RAS falls. CAS stays low for T_CHR clocks counted from the clock in which RAS falls. RAS stays low for T_RAS clocks.
- R8: After RAS rises, the strobes stay high for T_RP clocks before `ref_drive` is released.
- R9: When more refreshes are pending at the end of a cycle and the grant is still held, the next cycle follows without releasing `ref_drive`. In that case RAS is high for exactly T_RP+T_CSR clocks between the two cycles.
- R10: `pend_count` drops by one when a cycle's precharge ends. A tick that lands on the same clock leaves it unchanged, so in the run phase every tick that did not arrive while the counter was full is accounted for by either a completed cycle or a pending count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Bus grant from the access controller; must be held while `ref_drive` is high |
| ref_req | output | 1 | Refresh work is pending |
| ref_drive | output | 1 | Scheduler owns the strobes (cycle in progress) |
| ref_ras_n | output | 1 | Row strobe, active low |
| ref_cas_n | output | 1 | Column strobe (both byte lanes), active low |
| ready | output | 1 | Power-up sequence complete, normal access allowed |
| pend_count | output | $clog2(PEND_MAX+1) | Number of refreshes owed |

## Verification
The assertions check on every cycle that the strobes follow CAS-before-RAS order and are idle whenever the block does not own the bus. They also check that a cycle starts only under grant, that the RAS low time is exact, that the pending count stays bounded, and that `ready` is sticky. Only the bench scenarios can show the pause length, the wake burst count, where the interval ticks fall, what happens to ticks when the counter is full, the precharge gaps between cycles in a burst, and the accounting of ticks against completed cycles under random grant patterns.

// File: rtl/dram_ref_pkg.sv
// Shared types for the refresh scheduler.
package dram_ref_pkg;
    // Strobe sequencer states, one CAS-before-RAS cycle in order
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SETUP = 2'd1,
        SEQ_ACT   = 2'd2,
        SEQ_PRE   = 2'd3
    } seq_state_e;

    // Power-up phases of the scheduler
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WAKE  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;
endpackage

// File: rtl/dram_ref_interval.sv
// Interval timer: emits one tick every INTERVAL_CYCLES clocks while run is high.
// Assumes INTERVAL_CYCLES >= 2. Clearing run restarts the count from zero.
module dram_ref_interval #(
    parameter int INTERVAL_CYCLES = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int ICW = $clog2(INTERVAL_CYCLES + 1);

    logic [ICW-1:0] cnt_q;

    assign tick = run && (cnt_q == ICW'(INTERVAL_CYCLES - 1));

    // Free-running modulo counter, held at zero outside the run phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dram_ref_pending.sv
// Saturating pending-refresh counter with a preload for the wake-up burst.
// Assumes dec is only raised while the count is nonzero.
module dram_ref_pending #(
    parameter int PEND_MAX = 8,
    parameter int PCW      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [PCW-1:0] load_val,
    input  logic           inc,
    input  logic           dec,
    output logic [PCW-1:0] count,
    output logic [PCW-1:0] count_next
);
    logic [PCW-1:0] cnt_q;

    // Next value: preload wins, otherwise add ticks and remove completed cycles
    always_comb begin
        count_next = cnt_q;
        if (load)
            count_next = load_val;
        else if (inc && !dec && (cnt_q != PCW'(PEND_MAX)))
            count_next = cnt_q + 1'b1;
        else if (dec && !inc)
            count_next = cnt_q - 1'b1;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= count_next;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dram_ref_cbr_seq.sv
// Strobe sequencer for one CAS-before-RAS refresh cycle:
// SETUP (CAS low) -> ACT (RAS low, CAS released after T_CHR) -> PRE (both high).
// Assumes T_CSR >= 1, 1 <= T_CHR <= T_RAS, T_RP >= 1, and grant held while active.
module dram_ref_cbr_seq
    import dram_ref_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_CHR = 2,
    parameter int T_RAS = 6,
    parameter int T_RP  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic more_ok,
    output logic ras_n,
    output logic cas_n,
    output logic active,
    output logic done
);
    localparam int MAX_A = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int MAXT  = (MAX_A > T_RP) ? MAX_A : T_RP;
    localparam int CW    = $clog2(MAXT + 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    assign done   = (state_q == SEQ_PRE) && (cnt_q == '0);
    assign active = (state_q != SEQ_IDLE);
    assign ras_n  = (state_q != SEQ_ACT);
    assign cas_n  = !((state_q == SEQ_SETUP) ||
                      ((state_q == SEQ_ACT) && (cnt_q >= CW'(T_RAS - T_CHR))));

    // Phase walk with a down-counter loaded with each phase length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start_ok) begin
                    state_q <= SEQ_SETUP;
                    cnt_q   <= CW'(T_CSR - 1);
                end
                SEQ_SETUP: if (cnt_q == '0) begin
                    state_q <= SEQ_ACT;
                    cnt_q   <= CW'(T_RAS - 1);
                end else cnt_q <= cnt_q - 1'b1;
                SEQ_ACT: if (cnt_q == '0) begin
                    state_q <= SEQ_PRE;
                    cnt_q   <= CW'(T_RP - 1);
                end else cnt_q <= cnt_q - 1'b1;
                SEQ_PRE: if (cnt_q == '0) begin
                    state_q <= more_ok ? SEQ_SETUP : SEQ_IDLE;
                    cnt_q   <= more_ok ? CW'(T_CSR - 1) : '0;
                end else cnt_q <= cnt_q - 1'b1;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_ref_sched.sv
// Refresh scheduler top: power-up pause, wake-up burst, periodic refresh.
// Assumes the access controller holds ref_gnt for as long as ref_drive is high,
// and that WAKE_CYCLES <= PEND_MAX.
module dram_ref_sched
    import dram_ref_pkg::*;
#(
    parameter int INIT_CYCLES     = 20000,
    parameter int WAKE_CYCLES     = 8,
    parameter int INTERVAL_CYCLES = 1562,
    parameter int PEND_MAX        = 8,
    parameter int T_CSR           = 1,
    parameter int T_CHR           = 2,
    parameter int T_RAS           = 6,
    parameter int T_RP            = 4,
    localparam int PCW            = $clog2(PEND_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_gnt,
    output logic           ref_req,
    output logic           ref_drive,
    output logic           ref_ras_n,
    output logic           ref_cas_n,
    output logic           ready,
    output logic [PCW-1:0] pend_count
);
    localparam int PSW = $clog2(INIT_CYCLES + 1);

    phase_e         phase_q;
    logic [PSW-1:0] pause_q;
    logic           pause_end;
    logic           tick;
    logic           cyc_done;
    logic [PCW-1:0] pend_next;

    assign pause_end = (phase_q == PH_PAUSE) && (pause_q == PSW'(INIT_CYCLES - 1));

    // Power-up phase tracking: pause, wake burst, then steady running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PAUSE;
            pause_q <= '0;
        end else begin
            unique case (phase_q)
                PH_PAUSE: begin
                    if (pause_end) phase_q <= PH_WAKE;
                    else           pause_q <= pause_q + 1'b1;
                end
                PH_WAKE: if (cyc_done && (pend_next == '0)) phase_q <= PH_RUN;
                default: phase_q <= phase_q;
            endcase
        end
    end

    dram_ref_interval #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) interval_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (phase_q == PH_RUN),
        .tick (tick)
    );

    dram_ref_pending #(
        .PEND_MAX(PEND_MAX),
        .PCW     (PCW)
    ) pending_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pause_end),
        .load_val  (PCW'(WAKE_CYCLES)),
        .inc       (tick),
        .dec       (cyc_done),
        .count     (pend_count),
        .count_next(pend_next)
    );

    dram_ref_cbr_seq #(
        .T_CSR(T_CSR),
        .T_CHR(T_CHR),
        .T_RAS(T_RAS),
        .T_RP (T_RP)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ok((pend_count != '0) && ref_gnt),
        .more_ok ((pend_next != '0) && ref_gnt),
        .ras_n   (ref_ras_n),
        .cas_n   (ref_cas_n),
        .active  (ref_drive),
        .done    (cyc_done)
    );

    assign ref_req = (pend_count != '0);
    assign ready   = (phase_q == PH_RUN);
endmodule

// File: rtl/dram_ref_sched_chk.sv
// Protocol checker for dram_ref_sched; attached by bind below.
module dram_ref_sched_chk #(
    parameter int T_RAS    = 6,
    parameter int PEND_MAX = 8,
    parameter int PCW      = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ref_gnt,
    input logic           ref_drive,
    input logic           ref_ras_n,
    input logic           ref_cas_n,
    input logic           ready,
    input logic [PCW-1:0] pend_count
);
    logic [15:0] ras_low_q;

    // Length of the current RAS-low stretch
    always_ff @(posedge clk) begin
        if (!rst_n)          ras_low_q <= '0;
        else if (!ref_ras_n) ras_low_q <= ras_low_q + 1'b1;
        else                 ras_low_q <= '0;
    end

    assert_strobes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_drive |-> (ref_ras_n && ref_cas_n));
    assert_start_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_drive) |-> ref_gnt);
    assert_cas_before_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_ras_n) |-> $past(!ref_cas_n) && !ref_cas_n);
    assert_cas_falls_ras_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_cas_n) |-> ref_ras_n);
    assert_ras_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ras_n) |-> (ras_low_q == 16'(T_RAS)));
    assert_pend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= PCW'(PEND_MAX));
    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

bind dram_ref_sched dram_ref_sched_chk #(
    .T_RAS   (T_RAS),
    .PEND_MAX(PEND_MAX),
    .PCW     (PCW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_gnt   (ref_gnt),
    .ref_drive (ref_drive),
    .ref_ras_n (ref_ras_n),
    .ref_cas_n (ref_cas_n),
    .ready     (ready),
    .pend_count(pend_count)
);

// File: tb/dram_ref_sched_tb_top.sv
// Bench for dram_ref_sched: directed power-up and saturation scenarios,
// a strobe monitor on every cycle, and a seeded random grant phase.
module dram_ref_sched_tb_top;
    localparam int INIT  = 300;
    localparam int WAKE  = 8;
    localparam int IVL   = 120;
    localparam int PMAX  = 8;
    localparam int TCSR  = 1;
    localparam int TCHR  = 2;
    localparam int TRAS  = 6;
    localparam int TRP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ref_req, ref_drive, ref_ras_n, ref_cas_n, ready;
    logic [3:0] pend_count;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int falls = 0;
    bit mon_en = 1'b0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    dram_ref_sched #(
        .INIT_CYCLES(INIT), .WAKE_CYCLES(WAKE), .INTERVAL_CYCLES(IVL),
        .PEND_MAX(PMAX), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ref_drive(ref_drive), .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n),
        .ready(ready), .pend_count(pend_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic int ticks_since(input int start, input int now);
        return (now - start) / IVL;
    endfunction

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Clocks since reset release
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Strobe monitor: measures every phase length of every refresh cycle
    int  csr_len = 0, chr_len = 0, rlow_len = 0, gap_len = 0;
    bit  prev_ras = 1'b1, prev_drive = 1'b0, in_burst = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (!ref_drive)
                check(ref_ras_n && ref_cas_n, "R6", "strobes idle without drive",
                      {ref_ras_n, ref_cas_n}, 3);
            if (ref_ras_n && !ref_cas_n) csr_len++;
            else if (ref_ras_n)          csr_len = 0;
            if (prev_ras && !ref_ras_n) begin
                check(csr_len == TCSR, "R7", "CAS setup before RAS", csr_len, TCSR);
                if (in_burst)
                    check(gap_len == TRP + TCSR, "R9", "RAS high between burst cycles",
                          gap_len, TRP + TCSR);
                falls++;
                rlow_len = 1;
                chr_len  = ref_cas_n ? 0 : 1;
                csr_len  = 0;
            end else if (!ref_ras_n) begin
                rlow_len++;
                if (!ref_cas_n) chr_len++;
            end else if (!prev_ras && ref_ras_n) begin
                check(rlow_len == TRAS, "R7", "RAS low width", rlow_len, TRAS);
                check(chr_len == TCHR, "R7", "CAS hold after RAS", chr_len, TCHR);
                gap_len  = 1;
                in_burst = 1'b1;
            end else begin
                gap_len++;
            end
            if (prev_drive && !ref_drive)
                check(gap_len == TRP + 1, "R8", "precharge before release",
                      gap_len - 1, TRP);
            if (!ref_drive) in_burst = 1'b0;
            prev_ras   = ref_ras_n;
            prev_drive = ref_drive;
        end
    end

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int r_cyc, f0, tb0, fb0, pb0, tk;
        void'($urandom(32'd20240611));
        ref_gnt = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ref_req == 0 && ref_drive == 0 && ready == 0, "R1", "req/drive/ready in reset",
              {ref_req, ref_drive, ready}, 0);
        check(ref_ras_n && ref_cas_n && pend_count == 0, "R1", "strobes/pend in reset",
              pend_count, 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check(ref_req == 0 && pend_count == 0, "R1", "state just after reset", pend_count, 0);

        // R2: pause length and wake preload
        wait_cyc(INIT - 1);
        check(ref_req == 0, "R2", "req low at end of pause", ref_req, 0);
        wait_cyc(INIT);
        check(ref_req == 1, "R2", "req high after pause", ref_req, 1);
        check(pend_count == WAKE, "R2", "wake preload", pend_count, WAKE);
        check(ready == 0, "R3", "not ready during wake", ready, 0);

        // R3: ready after eight wake cycles
        while (!ready) @(negedge clk);
        r_cyc = cyc;
        check(falls == WAKE, "R3", "wake cycles before ready", falls, WAKE);
        check(pend_count == 0 && ref_req == 0, "R6", "req low with nothing pending",
              pend_count, 0);
        ref_gnt = 1'b0;

        // R4: interval ticks
        wait_cyc(r_cyc + IVL - 1);
        check(pend_count == 0, "R4", "no tick before interval", pend_count, 0);
        wait_cyc(r_cyc + IVL);
        check(pend_count == 1, "R4", "first tick", pend_count, 1);
        check(ref_req == 1 && ref_drive == 0, "R6", "no start without grant", ref_drive, 0);
        wait_cyc(r_cyc + 2 * IVL);
        check(pend_count == 2, "R4", "second tick", pend_count, 2);

        // R5: saturation with ten intervals owed
        wait_cyc(r_cyc + 10 * IVL);
        check(pend_count == PMAX, "R5", "saturated count", pend_count, PMAX);
        check(ready == 1, "R3", "ready stays high", ready, 1);
        f0 = falls;
        ref_gnt = 1'b1;
        wait_cyc(r_cyc + 10 * IVL + 100);
        check(falls - f0 == PMAX, "R5", "burst length after saturation", falls - f0, PMAX);
        check(pend_count == 0 && ref_drive == 0, "R10", "burst drained", pend_count, 0);
        ref_gnt = 1'b0;

        // R6: pending work waits for grant
        wait_cyc(r_cyc + 11 * IVL + 5);
        check(pend_count == 1 && ref_drive == 0 && ref_ras_n, "R6", "waiting for grant",
              ref_drive, 0);

        // R10: random grant pattern, ticks accounted for by cycles and pending count
        tb0 = ticks_since(r_cyc, cyc);
        fb0 = falls;
        pb0 = pend_count;
        for (int i = 0; i < 30 * IVL; i++) begin
            @(negedge clk);
            if (!ref_drive) ref_gnt = ($urandom % 4) != 0;
            if ((i % 37) == 0 && !ref_drive) begin
                tk = ticks_since(r_cyc, cyc) - tb0;
                check(tk == (falls - fb0) + pend_count - pb0, "R10", "tick accounting",
                      (falls - fb0) + pend_count - pb0, tk);
            end
        end
        ref_gnt = 1'b1;
        repeat (40) @(negedge clk);
        while (ref_drive) @(negedge clk);
        tk = ticks_since(r_cyc, cyc) - tb0;
        check(tk == (falls - fb0) + pend_count - pb0, "R10", "final tick accounting",
              (falls - fb0) + pend_count - pb0, tk);
        check(pend_count == 0, "R10", "all pending served", pend_count, 0);
        finish_run();
    end
endmodule